// File: doc/BRIEF.md
# Selectable 16/32-bit Frame Check Engine

This block computes the frame check sequence of a bit-oriented serial link, one bit per clock at most. It serves both directions of the link. On the transmit side, payload bits go in one at a time and the complemented check value is then drawn out serially, least significant bit first, for appending to the frame. On the receive side, every bit of the frame, check field included, goes in. A flag then reports whether the remainder left in the register is the constant that only an intact frame produces.

A static select input picks the 16-bit or the 32-bit generator polynomial. Both widths share one 32-bit shift register. In narrow mode the upper half stays zero. Bits are processed in line order, least significant bit first, so the register holds the check value in reflected form. A bit-valid strobe marks the bits that take part, which lets the framing logic around the block leave stuffed bits out. A clock enable gates every action of the block, including the clear.

Top module: `fcs_engine`

## Requirements
- R1: After synchronous reset, the register is all ones over the selected width. `fcs_bit` is then 0 and `residue_ok` is 0.
- R2: With `wide_sel`=0, the polynomial is x^16+x^12+x^5+1. The 16-bit check value of the ASCII bytes "123456789", each sent LSB first, is drawn out as 0x906E.
- R3: With `wide_sel`=1, the 32-bit polynomial with terms 32,26,23,22,16,12,11,10,8,7,5,4,2,1,0 is used. The check value of the same nine bytes is drawn out as 0xCBF43926.
- R4: The value drawn out is the bitwise complement of the register, LSB first. On `fcs_bit`, an empty frame therefore yields all zeros in either width.
- R5: A cycle with `ce`=1 and `frame_clr`=1 presets the register to all ones, whatever bits came before.
- R6: A cycle with `ce`=1 and `bit_vld`=0 and no clear or shift leaves the register unchanged, whatever `bit_in` is.
- R7: A cycle with `ce`=0 leaves the register unchanged, even when `frame_clr`, `bit_vld` or `fcs_shift` is high.
- R8: In 16-bit mode, feeding a frame followed by its own check value sets `residue_ok` to 1, because the register then holds 0xF0B8. A frame with one flipped bit leaves `residue_ok` at 0.
- R9: In 32-bit mode, the same procedure sets `residue_ok` to 1, because the register then holds 0xDEBB20E3. A corrupted frame leaves it at 0.
- R10: Among the actions taken when `ce`=1, `frame_clr` has the highest priority, then `fcs_shift`, then `bit_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for every action |
| frame_clr | input | 1 | Preset the register at frame start |
| bit_vld | input | 1 | `bit_in` takes part in the division |
| bit_in | input | 1 | Serial data bit, line order |
| fcs_shift | input | 1 | Advance the check value by one bit |
| wide_sel | input | 1 | 0: 16-bit polynomial, 1: 32-bit polynomial (static) |
| fcs_bit | output | 1 | Current complemented check bit |
| residue_ok | output | 1 | Register equals the good-frame residue |

## Verification
The nine-byte ASCII pattern is run in both widths against its published check values. This separates the two polynomials and also catches errors in bit order and in the complement. The same payload is sent a second time with idle cycles that carry garbage on `bit_in` and with cycles where the enable is low but the other inputs are active. Matching values there show that only strobed, enabled bits count. Looping each check value back after its frame tells the good residue apart from a frame with one corrupted bit. An empty frame, a clear that arrives mid-frame, and a clear presented together with a valid bit cover the preset and the priority order.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int REG_W    = 32;
    localparam int NARROW_W = 16;

    typedef logic [REG_W-1:0] crc_t;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } fcs_mode_e;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_PRESET = 2'd1,
        OP_DRAIN  = 2'd2,
        OP_ABSORB = 2'd3
    } crc_op_e;

    typedef struct packed {
        crc_op_e op;
        logic    data;
    } crc_cmd_t;

    // Reflected generator polynomials (LSB-first processing)
    localparam crc_t POLY_NARROW = 32'h0000_8408;
    localparam crc_t POLY_WIDE   = 32'hEDB8_8320;

    // Remainder left by an intact frame, including its check field
    localparam crc_t GOOD_NARROW = 32'h0000_F0B8;
    localparam crc_t GOOD_WIDE   = 32'hDEBB_20E3;

    function automatic crc_t width_mask(fcs_mode_e mode);
        return (mode == MODE_WIDE) ? {REG_W{1'b1}}
                                   : crc_t'({NARROW_W{1'b1}});
    endfunction

    function automatic crc_t top_bit(fcs_mode_e mode);
        return (mode == MODE_WIDE) ? crc_t'(1) << (REG_W - 1)
                                   : crc_t'(1) << (NARROW_W - 1);
    endfunction

    function automatic crc_t absorb_bit(crc_t cur, logic b, fcs_mode_e mode);
        crc_t nxt;
        logic fb;
        fb  = cur[0] ^ b;
        nxt = (cur >> 1) & width_mask(mode);
        if (fb) begin
            nxt = nxt ^ ((mode == MODE_WIDE) ? POLY_WIDE : POLY_NARROW);
        end
        return nxt;
    endfunction

    // Shift the check value out; refill with ones so a drained register
    // ends up preset again
    function automatic crc_t drain_bit(crc_t cur, fcs_mode_e mode);
        return ((cur >> 1) & width_mask(mode)) | top_bit(mode);
    endfunction

endpackage

// File: rtl/fcs_op_decode.sv
module fcs_op_decode
    import fcs_pkg::*;
(
    input  logic     ce,
    input  logic     frame_clr,
    input  logic     fcs_shift,
    input  logic     bit_vld,
    input  logic     bit_in,
    output crc_cmd_t cmd
);
    always_comb begin
        cmd.data = bit_in;
        if (!ce) begin
            cmd.op = OP_HOLD;
        end else if (frame_clr) begin
            cmd.op = OP_PRESET;
        end else if (fcs_shift) begin
            cmd.op = OP_DRAIN;
        end else if (bit_vld) begin
            cmd.op = OP_ABSORB;
        end else begin
            cmd.op = OP_HOLD;
        end
    end
endmodule

// File: rtl/fcs_shift_reg.sv
module fcs_shift_reg
    import fcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  crc_cmd_t  cmd,
    input  fcs_mode_e mode,
    output crc_t      crc_q
);
    crc_t crc_d;

    always_comb begin
        unique case (cmd.op)
            OP_PRESET: crc_d = width_mask(mode);
            OP_DRAIN:  crc_d = drain_bit(crc_q, mode);
            OP_ABSORB: crc_d = absorb_bit(crc_q, cmd.data, mode);
            default:   crc_d = crc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= width_mask(mode);
        end else begin
            crc_q <= crc_d;
        end
    end
endmodule

// File: rtl/fcs_residue_chk.sv
module fcs_residue_chk
    import fcs_pkg::*;
(
    input  crc_t      crc_q,
    input  fcs_mode_e mode,
    output logic      match
);
    crc_t good;

    always_comb begin
        good  = (mode == MODE_WIDE) ? GOOD_WIDE : GOOD_NARROW;
        match = ((crc_q & width_mask(mode)) == good);
    end
endmodule

// File: rtl/fcs_engine.sv
module fcs_engine
    import fcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic frame_clr,
    input  logic bit_vld,
    input  logic bit_in,
    input  logic fcs_shift,
    input  logic wide_sel,
    output logic fcs_bit,
    output logic residue_ok
);
    fcs_mode_e mode;
    crc_cmd_t  cmd;
    crc_t      crc_q;

    assign mode = fcs_mode_e'(wide_sel);

    fcs_op_decode u_dec (
        .ce        (ce),
        .frame_clr (frame_clr),
        .fcs_shift (fcs_shift),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .cmd       (cmd)
    );

    fcs_shift_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .mode  (mode),
        .crc_q (crc_q)
    );

    fcs_residue_chk u_res (
        .crc_q (crc_q),
        .mode  (mode),
        .match (residue_ok)
    );

    // Transmitted check bits are the complement of the register, LSB first
    assign fcs_bit = ~crc_q[0];

endmodule

// File: rtl/fcs_engine_chk.sv
module fcs_engine_chk (
    input logic clk,
    input logic rst,
    input logic ce,
    input logic frame_clr,
    input logic bit_vld,
    input logic bit_in,
    input logic fcs_shift,
    input logic wide_sel,
    input logic fcs_bit,
    input logic residue_ok
);
    // R5: after an enabled clear the low register bit is one, so the output bit is zero
    p_clr_bit_r5: assert property (@(posedge clk) disable iff (rst)
        (ce && frame_clr) |=> (fcs_bit == 1'b0));

    // R5: a freshly preset register never equals a good residue
    p_clr_residue_r5: assert property (@(posedge clk) disable iff (rst)
        (ce && frame_clr) |=> !residue_ok);

    // R6: unstrobed enabled cycles change nothing visible
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ce && !frame_clr && !fcs_shift && !bit_vld && $stable(wide_sel))
        |=> ($stable(fcs_bit) && $stable(residue_ok)));

    // R7: disabled cycles change nothing visible
    p_ce_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!ce && $stable(wide_sel)) |=> ($stable(fcs_bit) && $stable(residue_ok)));

    // R10: clear wins over a simultaneous shift request
    p_clr_over_shift_r10: assert property (@(posedge clk) disable iff (rst)
        (ce && frame_clr && fcs_shift) |=> (fcs_bit == 1'b0));

    logic unused_in;
    assign unused_in = bit_in;
endmodule

bind fcs_engine fcs_engine_chk chk_i (.*);

// File: tb/fcs_engine_tb_top.sv
module fcs_engine_tb_top;

    logic clk = 1'b0;
    logic rst, ce, frame_clr, bit_vld, bit_in, fcs_shift, wide_sel;
    logic fcs_bit, residue_ok;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    always #10 clk = ~clk;

    fcs_engine dut_i (
        .clk        (clk),
        .rst        (rst),
        .ce         (ce),
        .frame_clr  (frame_clr),
        .bit_vld    (bit_vld),
        .bit_in     (bit_in),
        .fcs_shift  (fcs_shift),
        .wide_sel   (wide_sel),
        .fcs_bit    (fcs_bit),
        .residue_ok (residue_ok)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic c, logic clr, logic v, logic b, logic sh);
        @(negedge clk);
        ce = c; frame_clr = clr; bit_vld = v; bit_in = b; fcs_shift = sh;
        @(posedge clk);
        #2;
        ce = 1'b0; frame_clr = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; fcs_shift = 1'b0;
    endtask

    task automatic clear_frame();
        drive(1, 1, 0, 0, 0);
    endtask

    task automatic send_byte(logic [7:0] d, bit gaps);
        for (int i = 0; i < 8; i++) begin
            if (gaps) begin
                drive(1, 0, 0, ~d[i], 0);   // enabled, not strobed
                drive(0, 1, 1, ~d[i], 1);   // strobes present, enable low
            end
            drive(1, 0, 1, d[i], 0);
        end
    endtask

    task automatic send_digits(bit gaps, bit flip);
        for (int k = 0; k < 9; k++) begin
            logic [7:0] d;
            d = 8'h31 + 8'(k);
            if (flip && k == 4) d[3] = ~d[3];
            send_byte(d, gaps);
        end
    endtask

    task automatic read_fcs(int w, output logic [31:0] val);
        val = '0;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            val[i] = fcs_bit;
            ce = 1'b1; fcs_shift = 1'b1;
            @(posedge clk);
            #2;
            ce = 1'b0; fcs_shift = 1'b0;
        end
    endtask

    task automatic send_value(logic [31:0] v, int w);
        for (int i = 0; i < w; i++) drive(1, 0, 1, v[i], 0);
    endtask

    task automatic sample_ok(output logic ok);
        @(negedge clk);
        ok = residue_ok;
    endtask

    task automatic t_reset();
        wide_sel = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset fcs_bit", 32'(fcs_bit), 32'd0);
        check("R1 reset residue_ok", 32'(residue_ok), 32'd0);
    endtask

    task automatic t_empty();
        logic [31:0] v;
        wide_sel = 1'b0; clear_frame(); read_fcs(16, v);
        check("R4 empty narrow", v, 32'h0);
        wide_sel = 1'b1; clear_frame(); read_fcs(32, v);
        check("R4 empty wide", v, 32'h0);
    endtask

    task automatic t_known(bit wide);
        logic [31:0] v;
        wide_sel = wide; clear_frame();
        send_digits(0, 0);
        if (wide) begin
            read_fcs(32, v); check("R3 wide check value", v, 32'hCBF43926);
        end else begin
            read_fcs(16, v); check("R2 narrow check value", v, 32'h0000906E);
        end
    endtask

    task automatic t_gaps();
        logic [31:0] v;
        wide_sel = 1'b0; clear_frame();
        send_digits(1, 0);
        read_fcs(16, v);
        check("R6 R7 gaps narrow", v, 32'h0000906E);
        wide_sel = 1'b1; clear_frame();
        send_digits(1, 0);
        read_fcs(32, v);
        check("R6 R7 gaps wide", v, 32'hCBF43926);
    endtask

    task automatic t_loop(bit wide);
        logic [31:0] v;
        logic        ok;
        int          w;
        w = wide ? 32 : 16;
        wide_sel = wide;
        clear_frame(); send_digits(0, 0); read_fcs(w, v);
        clear_frame(); send_digits(0, 0); send_value(v, w); sample_ok(ok);
        check(wide ? "R9 residue good wide" : "R8 residue good narrow", 32'(ok), 32'd1);
        clear_frame(); send_digits(0, 1); send_value(v, w); sample_ok(ok);
        check(wide ? "R9 residue bad wide" : "R8 residue bad narrow", 32'(ok), 32'd0);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wide_sel = 1'b0;
        clear_frame();
        send_byte(8'hA5, 0); send_byte(8'h3C, 0);
        clear_frame();
        send_digits(0, 0); read_fcs(16, v);
        check("R5 clear mid frame", v, 32'h0000906E);
        // R10: clear beats a simultaneous strobed bit and shift
        send_byte(8'h77, 0);
        drive(1, 1, 1, 1, 1);
        send_digits(0, 0); read_fcs(16, v);
        check("R10 clear priority", v, 32'h0000906E);
        // R7: clear with enable low is ignored
        clear_frame();
        for (int k = 0; k < 4; k++) send_byte(8'h31 + 8'(k), 0);
        drive(0, 1, 0, 0, 0);
        for (int k = 4; k < 9; k++) send_byte(8'h31 + 8'(k), 0);
        read_fcs(16, v);
        check("R7 disabled clear", v, 32'h0000906E);
        // R10: shift beats a simultaneous strobed bit (first drawn bit of empty frame)
        clear_frame();
        drive(1, 0, 1, 1, 1);
        read_fcs(15, v);
        check("R10 shift over bit", v, 32'h0);
    endtask

    initial begin
        rst = 1'b1; ce = 1'b0; frame_clr = 1'b0; bit_vld = 1'b0;
        bit_in = 1'b0; fcs_shift = 1'b0; wide_sel = 1'b0;
        t_reset();
        t_empty();
        t_known(0);
        t_known(1);
        t_gaps();
        t_loop(0);
        t_loop(1);
        t_clear();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule